// File: doc/BRIEF.md
# SPI Master with Parity-Shaped Clock Divider

This block is a synchronous SPI master. It runs on the system clock and builds its serial clock from a programmable divider value `div`. The serial period is `div + 1` system cycles. With an odd divider the two clock halves are equal. With an even divider the low half is one cycle shorter than the high half. A divider of zero is treated as one, so the shortest serial period is two system cycles.

A one-cycle `start` pulse begins a transfer. On that pulse the block latches the transmit word, the divider and the word length (8 to 32 bits). It pulls the active-low select low at once. It drives the first bit one low-width later, and makes the first falling serial edge one full period after the select fell. Data goes out MSB first and changes on rising edges. Input data is captured on falling edges.

After the last falling edge comes one more low phase. On the rising edge that ends it, the block releases the data line, raises the select, updates the receive word and pulses `done` for one cycle. The serial clock idles high between transfers.

Top module: `spi_uneven_master`

## Requirements
- R1: Let `D = div`, or 1 when `div` is 0, and let the period `T = D + 1` system cycles. The first falling edge of `sclk` comes T cycles after `ss_n` falls, and each later falling edge comes T cycles after the one before.
- R2: Low width `L` and high width `H`: when D is odd, `L = H = T/2`; when D is even, `L = D/2` and `H = D/2 + 1`. Every low phase of `sclk` inside a transfer lasts L cycles and every high phase between two falling edges lasts H cycles.
- R3: `div = 0` behaves exactly like `div = 1`: a two-cycle period with one cycle low and one cycle high.
- R4: `mosi_oe` rises, and the first bit appears on `mosi`, L cycles after `ss_n` falls.
- R5: `mosi` changes only on rising `sclk` edges. It carries bits `tx_word[N-1]` down to `tx_word[0]` in that order. `miso` is captured at each falling `sclk` edge, and the N captured bits appear right-aligned in `rx_word`, first bit most significant, with the upper bits zero.
- R6: On the rising edge L cycles after the Nth falling edge, `mosi_oe` drops, `ss_n` rises and `done` is high for exactly one cycle. The whole transfer therefore spans `N*T + L` cycles from `ss_n` falling. `mosi` reads 0 while `mosi_oe` is low.
- R7: The effective word length N is `word_len` clamped to the range 8..32. A value below 8 gives 8 bits; a value above 32 gives 32 bits.
- R8: A `start` pulse during a transfer is ignored. The running transfer keeps its bits and timing, and no second transfer follows it.
- R9: After reset: `sclk` = 1, `ss_n` = 1, `mosi_oe` = 0, `done` = 0 and `rx_word` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transfer |
| tx_word | input | 32 | Word to send, low N bits used |
| div | input | 8 | Clock divider value |
| word_len | input | 6 | Bits per transfer, clamped to 8..32 |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock, idles high |
| ss_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data to the slave |
| mosi_oe | output | 1 | Output enable for `mosi` (1 = driven) |
| rx_word | output | 32 | Last received word, right-aligned |
| done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
Random transfers mix odd and even dividers, so a single formula covering both parities would fail the L/H width checks on one of the two. Directed runs with `div` at 0, 1 and 2 target the shortest periods, where an off-by-one in the phase counter changes the widths by half or more. Lengths of 5, 8, 32 and 40 separate correct clamping and MSB alignment from wrap-around. Independent transmit and slave words expose any swap between the launch edge and the capture edge. A `start` pulse sent in the middle of a transfer shows whether the latched values are protected.

// File: rtl/spi_uneven_master.sv
module spi_uneven_master #(
  parameter int MAX_W = 32,
  parameter int MIN_W = 8,
  parameter int DIV_W = 8,
  localparam int LEN_W = $clog2(MAX_W + 1),
  localparam int CNT_W = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [MAX_W-1:0] tx_word,
  input  logic [DIV_W-1:0] div,
  input  logic [LEN_W-1:0] word_len,
  input  logic             miso,
  output logic             sclk,
  output logic             ss_n,
  output logic             mosi,
  output logic             mosi_oe,
  output logic [MAX_W-1:0] rx_word,
  output logic             done
);

  typedef enum logic [2:0] {IDLE, LEAD, SETUP, LOW, HIGH} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt, lo_r, hi_r, plen;
  logic [LEN_W-1:0] n_r, bits, len_e;
  logic [MAX_W-1:0] tsh, rsh;
  logic [DIV_W-1:0] div_e;
  logic [CNT_W-1:0] per, lo, hi;
  logic             phase_end;

  assign div_e = (div == '0) ? DIV_W'(1) : div;
  assign per   = CNT_W'(div_e) + CNT_W'(1);
  assign lo    = div_e[0] ? (per >> 1) : CNT_W'(div_e >> 1);
  assign hi    = per - lo;
  assign len_e = (word_len < LEN_W'(MIN_W)) ? LEN_W'(MIN_W) :
                 (word_len > LEN_W'(MAX_W)) ? LEN_W'(MAX_W) : word_len;

  assign plen      = (st == LEAD || st == LOW) ? lo_r : hi_r;
  assign phase_end = (cnt == plen - CNT_W'(1));
  assign mosi      = mosi_oe ? tsh[MAX_W-1] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      cnt     <= '0;
      lo_r    <= '0;
      hi_r    <= '0;
      n_r     <= '0;
      bits    <= '0;
      tsh     <= '0;
      rsh     <= '0;
      rx_word <= '0;
      sclk    <= 1'b1;
      ss_n    <= 1'b1;
      mosi_oe <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == IDLE) begin
        if (start) begin
          st   <= LEAD;
          ss_n <= 1'b0;
          cnt  <= '0;
          lo_r <= lo;
          hi_r <= hi;
          n_r  <= len_e;
          bits <= '0;
          tsh  <= tx_word << (MAX_W - int'(len_e));
          rsh  <= '0;
        end
      end else if (!phase_end) begin
        cnt <= cnt + CNT_W'(1);
      end else begin
        cnt <= '0;
        case (st)
          LEAD: begin
            mosi_oe <= 1'b1;
            st      <= SETUP;
          end
          SETUP, HIGH: begin
            sclk <= 1'b0;
            rsh  <= {rsh[MAX_W-2:0], miso};
            st   <= LOW;
          end
          LOW: begin
            sclk <= 1'b1;
            if (bits == n_r - LEN_W'(1)) begin
              mosi_oe <= 1'b0;
              ss_n    <= 1'b1;
              done    <= 1'b1;
              rx_word <= rsh;
              st      <= IDLE;
            end else begin
              tsh  <= tsh << 1;
              bits <= bits + LEN_W'(1);
              st   <= HIGH;
            end
          end
          default: st <= IDLE;
        endcase
      end
    end
  end

  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> sclk);
  a_r4_oe_in_select: assert property (@(posedge clk) disable iff (!rst_n)
    mosi_oe |-> !ss_n);
  a_r5_mosi_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (mosi_oe && $past(mosi_oe) && !$stable(mosi)) |-> $rose(sclk));
  a_r5_fall_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (!ss_n && mosi_oe));
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_done_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($rose(ss_n) && $fell(mosi_oe) && $rose(sclk)));

endmodule

// File: tb/sim_spi_uneven_master.sv
module sim_spi_uneven_master;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] tx_word = '0, rx_word;
  logic [7:0]  div = 8'd1;
  logic [5:0]  word_len = 6'd8;
  logic        miso, sclk, ss_n, mosi, mosi_oe, done;
  int          checks = 0, errors = 0;
  logic [31:0] sword = '0;
  int          nbits = 8, sidx = 0;

  always #4 clk = ~clk;

  spi_uneven_master u0 (.clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
    .div(div), .word_len(word_len), .miso(miso), .sclk(sclk), .ss_n(ss_n),
    .mosi(mosi), .mosi_oe(mosi_oe), .rx_word(rx_word), .done(done));

  assign miso = sword[sidx];
  always @(negedge ss_n) sidx = nbits - 1;
  always @(posedge sclk) if (!ss_n && sidx > 0) sidx = sidx - 1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eff_len(input int ln);
    return ln < 8 ? 8 : (ln > 32 ? 32 : ln);
  endfunction

  function automatic logic [31:0] lmask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  task automatic xfer(input logic [31:0] tx, input logic [31:0] sw,
                      input logic [7:0] dv, input logic [5:0] ln, input bit poke);
    int d, t, l, h, n, c, oe_c, first_fall, last_fall, last_rise, nfall, done_c;
    bit bad_t, bad_l, bad_h, bad_ch;
    logic [31:0] got;
    logic ps, po, pm;
    d = (dv == 0) ? 1 : int'(dv);
    t = d + 1;
    l = (d % 2 == 1) ? t / 2 : d / 2;
    h = t - l;
    n = eff_len(int'(ln));
    @(negedge clk);
    tx_word = tx; div = dv; word_len = ln; sword = sw; nbits = n;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 select low after start", {63'd0, ss_n}, 64'd0);
    c = 0; oe_c = -1; first_fall = -1; last_fall = -1; last_rise = -1;
    nfall = 0; done_c = -1; got = '0;
    bad_t = 0; bad_l = 0; bad_h = 0; bad_ch = 0;
    ps = sclk; po = mosi_oe; pm = mosi;
    while (done_c < 0 && c < 20000) begin
      @(negedge clk);
      c++;
      if (poke && c == 2) begin start = 1'b1; tx_word = ~tx; word_len = 6'd9; div = 8'd3; end
      if (poke && c == 3) start = 1'b0;
      if (po && mosi_oe && mosi !== pm && !(sclk && !ps)) bad_ch = 1;
      if (mosi_oe && !po) oe_c = c;
      if (ps && !sclk) begin
        nfall++;
        got = {got[30:0], mosi};
        if (first_fall < 0) first_fall = c;
        else begin
          if (c - last_fall != t) bad_t = 1;
          if (c - last_rise != h) bad_h = 1;
        end
        last_fall = c;
      end
      if (!ps && sclk) begin
        if (c - last_fall != l) bad_l = 1;
        last_rise = c;
      end
      if (done) done_c = c;
      ps = sclk; po = mosi_oe; pm = mosi;
    end
    chk("R1 first fall one period after select", 64'(first_fall), 64'(t));
    chk("R1 fall-to-fall period", {63'd0, bad_t}, 64'd0);
    chk("R2 low width", {63'd0, bad_l}, 64'd0);
    chk("R2 high width", {63'd0, bad_h}, 64'd0);
    chk("R4 first data after low width", 64'(oe_c), 64'(l));
    chk("R5 mosi changes only on rise", {63'd0, bad_ch}, 64'd0);
    chk("R5 transmitted bits", {32'd0, got & lmask(n)}, {32'd0, tx & lmask(n)});
    chk("R5 received word", {32'd0, rx_word}, {32'd0, sw & lmask(n)});
    chk("R7 number of bits", 64'(nfall), 64'(n));
    chk("R6 transfer length", 64'(done_c), 64'(n * t + l));
    chk("R6 release at end", {61'd0, ss_n, mosi_oe, mosi}, {61'd0, 1'b1, 1'b0, 1'b0});
    @(negedge clk);
    chk("R6 done one cycle", {63'd0, done}, 64'd0);
    if (poke) begin
      repeat (6) begin
        @(negedge clk);
        chk("R8 no second transfer", {63'd0, ss_n}, 64'd1);
      end
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R9 reset state", {rx_word, 28'd0, sclk, ss_n, mosi_oe, done},
        {32'd0, 28'd0, 1'b1, 1'b1, 1'b0, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);
    xfer(32'hA5, 32'h3C, 8'd0, 6'd8, 0);            // R3 div zero
    xfer(32'h96, 32'hC3, 8'd1, 6'd8, 0);            // R3 same as div one
    xfer(32'h1234_5678, 32'h8765_4321, 8'd2, 6'd32, 0);
    xfer(32'hFFFF_FF5A, 32'h0000_00A5, 8'd3, 6'd5, 0);  // R7 short clamp
    xfer(32'hDEAD_BEEF, 32'hCAFE_F00D, 8'd4, 6'd40, 0); // R7 long clamp
    xfer(32'h0001_2345, 32'h0005_4321, 8'd5, 6'd20, 1); // R8 start ignored
    for (int i = 0; i < 30; i++)
      xfer($urandom, $urandom, 8'($urandom_range(0, 12)), 6'($urandom_range(8, 32)), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule